// File: doc/BRIEF.md
# Raster timing generator with early frame fetch

This block produces the horizontal and vertical timing for a display link in video mode. A mode is given as four values per axis: active size, sync start, sync end and total. The block turns these into a sync pulse width, a back porch and a front porch for each axis. It refuses modes whose values are out of order. It then drives hsync, vsync and a data-enable window, and it keeps a line counter and a frame counter.

The block also gives an early-fetch strobe. This strobe is placed in the vertical front porch of the frame that is running, so that the pixel source can start fetching the next frame before that frame begins. The strobe is placed early enough to cover a worst-case line latency, given as a parameter. Two interface types change how the timing is built. On a DSI-type link both syncs are forced active-high. On a DP-type link with the wide bus enabled, each front porch is folded into its back porch, and the horizontal values are halved.

The configuration pins are static. The block copies them only while it is disabled. Raising `enable` copies the mode, checks it and starts the raster. Dropping `enable` stops the raster at the end of the frame that is running, and the block then reports that the stop has taken effect.

Top module: `rg_top`

## Requirements
- R1: Every line starts with the sync region (hsw pixels), then the back porch (hbp), then the active region (hact), then the front porch (hfp). The lines of a frame follow the same order: vsw sync lines, vbp back-porch lines, vact active lines, vfp front-porch lines. The per-axis values are hfp = sync_start − active, hsw = sync_end − sync_start and hbp = total − sync_end. A frame lasts htot × vtot clocks, where htot and vtot are the sums of the four parts. `de` is high only where the active pixels and the active lines overlap.
- R2: A mode is rejected on either axis when total < sync_end, sync_start < active or sync_end < sync_start. A mode is also rejected when a derived total is zero. When a mode is rejected, `mode_err` goes to 1 and `active` stays 0. While `active` is 0, `de`, `vblank`, `fetch_strobe` and `fill_valid` are all 0.
- R3: `hsync_neg` = 1 makes hsync active-low, and `vsync_neg` = 1 makes vsync active-low. When `intf_sel` = 1 (DSI-type link), both syncs are active-high whatever the flags say.
- R4: When `intf_sel` = 2 (DP-type link) and `wide_bus` = 1, each front porch is added to its back porch and the front porch becomes 0. After that, the horizontal active width, back porch and sync width are each shifted right by one bit. With `wide_bus` = 0, or on any other link type, no fold and no halving take place.
- R5: Let W be the `WORST_LINES` parameter and S = vbp + vsw. The number of prefetch lines P is 0 when S ≥ W. It is vfp when vfp < W − S. Otherwise it is W − S. Prefetch is enabled only when P is not zero.
- R6: When prefetch is enabled, `fetch_strobe` is high for exactly one clock per frame. It fires when the 1-based pixel position in the frame, counted from the first sync pixel, equals (vtot − P) × htot + 1. When P = 0 the strobe never fires.
- R7: While the raster runs, `fill_valid` is high outside the data-enable window and also when `underflow` is 1. `fill_data` is 0xFF when `de` and `underflow` are both 1, and 0x00 in every other case.
- R8: `frame_count_rb` is `frame_count` + 1 when prefetch is enabled, the raster runs and the condition vtot − vfp < `line_count` ≤ vtot holds. In every other case it equals `frame_count`.
- R9: When `enable` falls, the raster continues to the end of the frame that is running. `disable_done` is then high for one clock, at the point where the next frame would have started, and `active` is 0 from that clock on. If `enable` rises again before the frame ends, the stop is cancelled.
- R10: The configuration inputs are copied only while the block is disabled. A change to them while `active` = 1 has no effect. A start begins at pixel 0 of line 0, with `frame_count` = 0.
- R11: `vblank` is high for one clock at the first pixel of every frame. `frame_count` increases by 1 at each frame wrap.
- R12: `line_count` is the 1-based number of the current line while the raster runs, and 0 while it is idle. After reset, the outputs `hsync`, `vsync`, `de`, `active` and `mode_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Requests that the raster runs |
| h_active | input | TW | Horizontal active pixels |
| h_sync_start | input | TW | Horizontal sync start position |
| h_sync_end | input | TW | Horizontal sync end position |
| h_total | input | TW | Horizontal total |
| v_active | input | TW | Vertical active lines |
| v_sync_start | input | TW | Vertical sync start line |
| v_sync_end | input | TW | Vertical sync end line |
| v_total | input | TW | Vertical total |
| hsync_neg | input | 1 | Makes hsync active-low |
| vsync_neg | input | 1 | Makes vsync active-low |
| intf_sel | input | 2 | Link type: 0 generic, 1 DSI, 2 DP, 3 other |
| wide_bus | input | 1 | Wide-bus mode (takes effect on DP only) |
| underflow | input | 1 | The pixel source has underflowed |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| fill_valid | output | 1 | Fill colour is being driven |
| fill_data | output | 8 | Fill colour value |
| fetch_strobe | output | 1 | Early-fetch strobe |
| vblank | output | 1 | Frame start pulse |
| line_count | output | TW | 1-based current line |
| frame_count | output | FW | Frames since start |
| frame_count_rb | output | FW | Frame count, adjusted for prefetch |
| active | output | 1 | Raster is running |
| mode_err | output | 1 | The last start attempt was rejected |
| disable_done | output | 1 | The stop has taken effect |

## Verification
The assertions take for granted that a valid mode is in place whenever the raster runs. They therefore treat htot and vtot as non-zero, and they rely on the copy of the mode staying frozen for as long as `active` is high. They also take for granted that `underflow` only matters while the raster runs. The stimulus changes the configuration and `enable` only on the falling clock edge. It uses small modes with non-zero sync widths, and it changes the configuration pins during a run only to show that such a change is ignored.

// File: rtl/rg_pkg.sv
package rg_pkg;
    parameter int unsigned TW     = 12;
    parameter int unsigned PW     = 2 * TW;
    parameter int unsigned FILL_W = 8;
    parameter logic [FILL_W-1:0] FILL_BORDER = 8'h00;
    parameter logic [FILL_W-1:0] FILL_UNDER  = 8'hFF;

    typedef logic [TW-1:0] tval_t;

    typedef enum logic [1:0] {
        IF_GENERIC = 2'd0,
        IF_DSI     = 2'd1,
        IF_DP      = 2'd2,
        IF_OTHER   = 2'd3
    } itf_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_RUN  = 2'd2
    } st_e;

    typedef struct packed {
        tval_t act;
        tval_t ss;
        tval_t se;
        tval_t tot;
    } axis_mode_t;

    typedef struct packed {
        axis_mode_t h;
        axis_mode_t v;
        logic       h_neg;
        logic       v_neg;
        itf_e       itf;
        logic       wide;
    } rg_mode_t;

    typedef struct packed {
        tval_t act;
        tval_t fp;
        tval_t sw;
        tval_t bp;
        tval_t tot;
    } axis_tim_t;

    typedef struct packed {
        axis_tim_t h;
        axis_tim_t v;
        logic      h_neg;
        logic      v_neg;
        logic      valid;
    } rg_tim_t;

    function automatic logic rg_axis_bad(axis_mode_t a);
        return (a.tot < a.se) || (a.ss < a.act) || (a.se < a.ss);
    endfunction

    function automatic axis_tim_t rg_split(axis_mode_t a);
        axis_tim_t t;
        t.act = a.act;
        t.fp  = a.ss - a.act;
        t.sw  = a.se - a.ss;
        t.bp  = a.tot - a.se;
        t.tot = a.tot;
        return t;
    endfunction

    function automatic rg_tim_t rg_derive(rg_mode_t m);
        rg_tim_t t;
        logic    fold;
        t.h  = rg_split(m.h);
        t.v  = rg_split(m.v);
        fold = (m.itf == IF_DP) && m.wide;
        if (fold) begin
            t.h.bp  = t.h.bp + t.h.fp;
            t.h.fp  = '0;
            t.v.bp  = t.v.bp + t.v.fp;
            t.v.fp  = '0;
            t.h.act = t.h.act >> 1;
            t.h.bp  = t.h.bp >> 1;
            t.h.sw  = t.h.sw >> 1;
        end
        t.h.tot = t.h.act + t.h.fp + t.h.sw + t.h.bp;
        t.v.tot = t.v.act + t.v.fp + t.v.sw + t.v.bp;
        t.h_neg = m.h_neg && (m.itf != IF_DSI);
        t.v_neg = m.v_neg && (m.itf != IF_DSI);
        t.valid = !rg_axis_bad(m.h) && !rg_axis_bad(m.v) &&
                  (t.h.tot != '0) && (t.v.tot != '0);
        return t;
    endfunction

    function automatic tval_t rg_prefetch_lines(axis_tim_t v, tval_t worst);
        logic [TW:0] s;
        logic [TW:0] need;
        s = {1'b0, v.bp} + {1'b0, v.sw};
        if (s >= {1'b0, worst}) begin
            return '0;
        end
        need = {1'b0, worst} - s;
        if ({1'b0, v.fp} < need) begin
            return v.fp;
        end
        return need[TW-1:0];
    endfunction

    function automatic logic rg_in_sync(tval_t p, axis_tim_t a);
        return p < a.sw;
    endfunction

    function automatic logic rg_in_active(tval_t p, axis_tim_t a);
        logic [TW:0] lo;
        logic [TW:0] hi;
        lo = {1'b0, a.sw} + {1'b0, a.bp};
        hi = lo + {1'b0, a.act};
        return ({1'b0, p} >= lo) && ({1'b0, p} < hi);
    endfunction
endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl
    import rg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  rg_mode_t mode_in,
    input  logic     frame_end,
    output rg_tim_t  tim,
    output logic     running,
    output logic     mode_err,
    output logic     done
);
    st_e      st_q;
    rg_mode_t shadow_q;
    rg_tim_t  tim_q;
    rg_tim_t  drv_c;
    logic     err_q;
    logic     done_q;

    assign drv_c = rg_derive(shadow_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            shadow_q <= '0;
            tim_q    <= '0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    shadow_q <= mode_in;
                    if (enable) st_q <= ST_PREP;
                end
                ST_PREP: begin
                    tim_q <= drv_c;
                    if (!enable) begin
                        st_q <= ST_IDLE;
                    end else if (drv_c.valid) begin
                        st_q  <= ST_RUN;
                        err_q <= 1'b0;
                    end else begin
                        st_q  <= ST_IDLE;
                        err_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (frame_end && !enable) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign tim      = tim_q;
    assign running  = (st_q == ST_RUN);
    assign mode_err = err_q;
    assign done     = done_q;

    // R10: the copied mode does not move while the raster runs
    p_shadow_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> ($stable(shadow_q) && $stable(tim_q)));

    // R9: the stop report follows a running frame
    p_done_from_run_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (st_q == ST_IDLE && $past(st_q) == ST_RUN));

    // R2: the raster only starts on an accepted mode
    p_start_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && $past(st_q) == ST_PREP) |-> tim_q.valid);
endmodule

// File: rtl/rg_raster.sv
module rg_raster
    import rg_pkg::*;
#(
    parameter int unsigned FW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  rg_tim_t       tim,
    output logic [PW-1:0] pix,
    output logic [FW-1:0] fcount,
    output tval_t         line_no,
    output logic          frame_end,
    output logic          hs_on,
    output logic          vs_on,
    output logic          de_on,
    output logic          vblank
);
    localparam int unsigned NAX = 2;

    tval_t         h_q;
    tval_t         v_q;
    logic [PW-1:0] pix_q;
    logic [FW-1:0] fc_q;
    logic          h_last;
    logic          v_last;

    tval_t     pos  [NAX];
    axis_tim_t ax   [NAX];
    logic      in_s [NAX];
    logic      in_a [NAX];

    assign pos[0] = h_q;
    assign pos[1] = v_q;
    assign ax[0]  = tim.h;
    assign ax[1]  = tim.v;

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        assign in_s[g] = rg_in_sync(pos[g], ax[g]);
        assign in_a[g] = rg_in_active(pos[g], ax[g]);
    end

    assign h_last    = (h_q == tim.h.tot - 1'b1);
    assign v_last    = (v_q == tim.v.tot - 1'b1);
    assign frame_end = run && h_last && v_last;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            h_q   <= '0;
            v_q   <= '0;
            fc_q  <= '0;
            pix_q <= PW'(1);
        end else begin
            pix_q <= frame_end ? PW'(1) : pix_q + 1'b1;
            if (h_last) begin
                h_q <= '0;
                if (v_last) begin
                    v_q  <= '0;
                    fc_q <= fc_q + 1'b1;
                end else begin
                    v_q <= v_q + 1'b1;
                end
            end else begin
                h_q <= h_q + 1'b1;
            end
        end
    end

    assign pix     = pix_q;
    assign fcount  = fc_q;
    assign line_no = run ? (v_q + 1'b1) : '0;
    assign hs_on   = run && in_s[0];
    assign vs_on   = run && in_s[1];
    assign de_on   = run && in_a[0] && in_a[1];
    assign vblank  = run && (h_q == '0) && (v_q == '0);

    // R1: pixel position stays inside the line
    p_hpos_range_r1: assert property (@(posedge clk) disable iff (rst)
        run |-> (h_q < tim.h.tot));

    // R12: line position stays inside the frame
    p_vpos_range_r12: assert property (@(posedge clk) disable iff (rst)
        run |-> (v_q < tim.v.tot));

    // R11: frame count steps by one, at a frame start
    p_frame_step_r11: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (fc_q != $past(fc_q))) |-> ((fc_q == $past(fc_q) + 1'b1) && vblank));
endmodule

// File: rtl/rg_fetch.sv
module rg_fetch
    import rg_pkg::*;
#(
    parameter int unsigned WORST_LINES = 24,
    parameter int unsigned FW          = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  rg_tim_t       tim,
    input  logic [PW-1:0] pix,
    input  tval_t         line_no,
    input  logic [FW-1:0] fcount,
    output logic          strobe,
    output logic [FW-1:0] fcount_rb
);
    localparam tval_t WORST = tval_t'(WORST_LINES);

    tval_t         pf_lines;
    logic          pf_on;
    logic [PW-1:0] target;
    logic [TW:0]   fp_floor;
    logic          in_fp_line;

    assign pf_lines = rg_prefetch_lines(tim.v, WORST);
    assign pf_on    = (pf_lines != '0);
    assign target   = PW'(tim.v.tot - pf_lines) * PW'(tim.h.tot) + PW'(1);
    assign strobe   = run && pf_on && (pix == target);

    assign fp_floor   = {1'b0, tim.v.tot} - {1'b0, tim.v.fp};
    assign in_fp_line = ({1'b0, line_no} > fp_floor) && (line_no <= tim.v.tot);
    assign fcount_rb  = (run && pf_on && in_fp_line) ? fcount + 1'b1 : fcount;

    // R6: the strobe lands on a front-porch line
    p_strobe_in_porch_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |-> ({1'b0, line_no} > fp_floor));

    // R8: the read-back count is never more than one ahead
    p_rb_step_r8: assert property (@(posedge clk) disable iff (rst)
        (fcount_rb == fcount) || (fcount_rb == fcount + 1'b1));
endmodule

// File: rtl/rg_top.sv
module rg_top
    import rg_pkg::*;
#(
    parameter int unsigned WORST_LINES = 24,
    parameter int unsigned FW          = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [TW-1:0]     h_active,
    input  logic [TW-1:0]     h_sync_start,
    input  logic [TW-1:0]     h_sync_end,
    input  logic [TW-1:0]     h_total,
    input  logic [TW-1:0]     v_active,
    input  logic [TW-1:0]     v_sync_start,
    input  logic [TW-1:0]     v_sync_end,
    input  logic [TW-1:0]     v_total,
    input  logic              hsync_neg,
    input  logic              vsync_neg,
    input  logic [1:0]        intf_sel,
    input  logic              wide_bus,
    input  logic              underflow,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              fill_valid,
    output logic [FILL_W-1:0] fill_data,
    output logic              fetch_strobe,
    output logic              vblank,
    output logic [TW-1:0]     line_count,
    output logic [FW-1:0]     frame_count,
    output logic [FW-1:0]     frame_count_rb,
    output logic              active,
    output logic              mode_err,
    output logic              disable_done
);
    rg_mode_t      mode_in;
    rg_tim_t       tim;
    logic          running;
    logic          frame_end;
    logic [PW-1:0] pix;
    logic [FW-1:0] fcount;
    tval_t         line_no;
    logic          hs_on;
    logic          vs_on;
    logic          de_on;

    always_comb begin
        mode_in.h.act = h_active;
        mode_in.h.ss  = h_sync_start;
        mode_in.h.se  = h_sync_end;
        mode_in.h.tot = h_total;
        mode_in.v.act = v_active;
        mode_in.v.ss  = v_sync_start;
        mode_in.v.se  = v_sync_end;
        mode_in.v.tot = v_total;
        mode_in.h_neg = hsync_neg;
        mode_in.v_neg = vsync_neg;
        mode_in.itf   = itf_e'(intf_sel);
        mode_in.wide  = wide_bus;
    end

    rg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .mode_in   (mode_in),
        .frame_end (frame_end),
        .tim       (tim),
        .running   (running),
        .mode_err  (mode_err),
        .done      (disable_done)
    );

    rg_raster #(.FW(FW)) u_raster (
        .clk       (clk),
        .rst       (rst),
        .run       (running),
        .tim       (tim),
        .pix       (pix),
        .fcount    (fcount),
        .line_no   (line_no),
        .frame_end (frame_end),
        .hs_on     (hs_on),
        .vs_on     (vs_on),
        .de_on     (de_on),
        .vblank    (vblank)
    );

    rg_fetch #(.WORST_LINES(WORST_LINES), .FW(FW)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .run       (running),
        .tim       (tim),
        .pix       (pix),
        .line_no   (line_no),
        .fcount    (fcount),
        .strobe    (fetch_strobe),
        .fcount_rb (frame_count_rb)
    );

    assign hsync       = hs_on ^ tim.h_neg;
    assign vsync       = vs_on ^ tim.v_neg;
    assign de          = de_on;
    assign fill_valid  = running && (!de_on || underflow);
    assign fill_data   = (de_on && underflow) ? FILL_UNDER : FILL_BORDER;
    assign line_count  = line_no;
    assign frame_count = fcount;
    assign active      = running;

    // R2: nothing leaves an idle or rejected block
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !active |-> (!de && !vblank && !fetch_strobe && !fill_valid));
endmodule

// File: tb/rg_top_tb_top.sv
module rg_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WL = 6;
    localparam int NV = 7;
    // hact hss hse htot vact vss vse vtot hneg vneg itf wide
    localparam int VT [NV][12] = '{
        '{ 8, 10, 12, 16, 4, 6, 7, 10, 0, 0, 0, 0},
        '{ 6,  7,  9, 12, 3, 8, 9, 11, 1, 1, 0, 0},
        '{10, 12, 14, 20, 4, 5, 8, 12, 1, 1, 1, 0},
        '{ 8,  9, 11, 14, 5, 6, 7,  9, 0, 1, 3, 0},
        '{16, 20, 24, 32, 4, 6, 8, 12, 0, 0, 2, 1},
        '{16, 20, 24, 32, 4, 6, 8, 12, 0, 0, 2, 0},
        '{ 9, 12, 15, 20, 3, 4, 5,  8, 1, 0, 2, 1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic [11:0] h_active = '0, h_sync_start = '0, h_sync_end = '0, h_total = '0;
    logic [11:0] v_active = '0, v_sync_start = '0, v_sync_end = '0, v_total = '0;
    logic hsync_neg = 1'b0, vsync_neg = 1'b0, wide_bus = 1'b0, underflow = 1'b0;
    logic [1:0] intf_sel = 2'd0;
    logic hsync, vsync, de, fill_valid, fetch_strobe, vblank, active, mode_err, disable_done;
    logic [7:0] fill_data;
    logic [11:0] line_count;
    logic [15:0] frame_count, frame_count_rb;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rg_top #(.WORST_LINES(WL), .FW(16)) dut_i (
        .clk(clk), .rst(rst), .enable(enable),
        .h_active(h_active), .h_sync_start(h_sync_start), .h_sync_end(h_sync_end), .h_total(h_total),
        .v_active(v_active), .v_sync_start(v_sync_start), .v_sync_end(v_sync_end), .v_total(v_total),
        .hsync_neg(hsync_neg), .vsync_neg(vsync_neg), .intf_sel(intf_sel), .wide_bus(wide_bus),
        .underflow(underflow), .hsync(hsync), .vsync(vsync), .de(de), .fill_valid(fill_valid),
        .fill_data(fill_data), .fetch_strobe(fetch_strobe), .vblank(vblank), .line_count(line_count),
        .frame_count(frame_count), .frame_count_rb(frame_count_rb), .active(active),
        .mode_err(mode_err), .disable_done(disable_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_mode(input int ha, hs, he, ht, va, vs, ve, vt, hn, vn, it, wb);
        h_active = 12'(ha); h_sync_start = 12'(hs); h_sync_end = 12'(he); h_total = 12'(ht);
        v_active = 12'(va); v_sync_start = 12'(vs); v_sync_end = 12'(ve); v_total = 12'(vt);
        hsync_neg = hn[0]; vsync_neg = vn[0]; intf_sel = 2'(it); wide_bus = wb[0];
    endtask

    task automatic wait_vblank(output int ok);
        int n;
        n = 0;
        @(negedge clk);
        while (!vblank && n < 2000) begin
            @(negedge clk);
            n++;
        end
        ok = vblank ? 1 : 0;
    endtask

    // starts at a negedge with vblank high; ends at the next frame start
    task automatic measure_frame(input int hlev, input int vlev,
                                 output int flen, output int nde, output int nhs, output int nvs,
                                 output int fde, output int sidx, output int sline, output int srb);
        int n;
        n = 0; nde = 0; nhs = 0; nvs = 0; fde = -1; sidx = -1; sline = 0; srb = -1;
        do begin
            if (de) begin
                nde++;
                if (fde < 0) fde = n;
            end
            if (hsync == hlev[0]) nhs++;
            if (vsync == vlev[0]) nvs++;
            if (fetch_strobe) begin
                if (sidx < 0) begin
                    sidx = n; sline = int'(line_count); srb = int'(frame_count_rb);
                end else begin
                    sidx = -2;
                end
            end
            @(negedge clk);
            n++;
        end while (!vblank && n < 20000);
        flen = n;
    endtask

    task automatic stop_count(output int m);
        m = 0;
        enable = 1'b0;
        while (!disable_done && m < 20000) begin
            @(negedge clk);
            m++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int ok, flen, nde, nhs, nvs, fde, sidx, sline, srb, m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset hsync", int'(hsync), 0);
        chk("R12 reset vsync", int'(vsync), 0);
        chk("R12 reset de", int'(de), 0);
        chk("R12 reset active", int'(active), 0);
        chk("R12 reset mode_err", int'(mode_err), 0);
        chk("R12 reset line_count", int'(line_count), 0);

        for (int i = 0; i < NV; i++) begin
            int hact, hfp, hsw, hbp, vact, vfp, vsw, vbp, htot, vtot, s, pl, hlev, vlev;
            hact = VT[i][0]; hfp = VT[i][1] - VT[i][0]; hsw = VT[i][2] - VT[i][1]; hbp = VT[i][3] - VT[i][2];
            vact = VT[i][4]; vfp = VT[i][5] - VT[i][4]; vsw = VT[i][6] - VT[i][5]; vbp = VT[i][7] - VT[i][6];
            hlev = (VT[i][8] != 0 && VT[i][10] != 1) ? 0 : 1;
            vlev = (VT[i][9] != 0 && VT[i][10] != 1) ? 0 : 1;
            if (VT[i][10] == 2 && VT[i][11] != 0) begin
                hbp = hbp + hfp; hfp = 0; vbp = vbp + vfp; vfp = 0;
                hact = hact / 2; hbp = hbp / 2; hsw = hsw / 2;
            end
            htot = hact + hfp + hsw + hbp;
            vtot = vact + vfp + vsw + vbp;
            s = vbp + vsw;
            pl = (s >= WL) ? 0 : ((vfp < WL - s) ? vfp : WL - s);

            set_mode(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5], VT[i][6], VT[i][7],
                     VT[i][8], VT[i][9], VT[i][10], VT[i][11]);
            enable = 1'b1;
            wait_vblank(ok);
            chk("R10 start", ok, 1);
            chk("R10 frame_count at start", int'(frame_count), 0);
            chk("R12 first line number", int'(line_count), 1);
            chk("R8 readback outside porch", int'(frame_count_rb), 0);
            chk("R3 hsync level at frame start", int'(hsync), hlev);
            chk("R3 vsync level at frame start", int'(vsync), vlev);
            measure_frame(hlev, vlev, flen, nde, nhs, nvs, fde, sidx, sline, srb);
            chk("R1 R4 frame length", flen, htot * vtot);
            chk("R1 R4 de count", nde, hact * vact);
            chk("R1 R3 hsync active count", nhs, hsw * vtot);
            chk("R1 R3 vsync active count", nvs, vsw * htot);
            chk("R1 first de position", fde, (vsw + vbp) * htot + hsw + hbp);
            chk("R5 R6 strobe position", sidx, (pl == 0) ? -1 : (vtot - pl) * htot);
            if (pl != 0) begin
                chk("R12 line at strobe", sline, vtot - pl + 1);
                chk("R8 readback at strobe", srb, 1);
            end
            chk("R11 vblank at next frame", int'(vblank), 1);
            chk("R11 frame_count after wrap", int'(frame_count), 1);
            stop_count(m);
            chk("R9 stop at frame boundary", m, htot * vtot);
            chk("R9 inactive after stop", int'(active), 0);
            chk("R12 idle line_count", int'(line_count), 0);
            @(negedge clk);
            chk("R9 done is one clock", int'(disable_done), 0);
        end

        // R2 invalid modes
        set_mode(8, 7, 12, 16, 4, 6, 7, 10, 0, 0, 0, 0);
        enable = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 sync_start below active err", int'(mode_err), 1);
        chk("R2 rejected stays inactive", int'(active), 0);
        chk("R2 rejected no de", int'(de), 0);
        enable = 1'b0;
        set_mode(8, 10, 12, 16, 4, 6, 11, 10, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        enable = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 total below sync_end err", int'(mode_err), 1);
        chk("R2 rejected vertical inactive", int'(active), 0);
        enable = 1'b0;
        repeat (2) @(negedge clk);

        // R10 config change ignored while running
        set_mode(8, 10, 12, 16, 4, 6, 7, 10, 0, 0, 0, 0);
        enable = 1'b1;
        wait_vblank(ok);
        chk("R2 valid mode clears err", int'(mode_err), 0);
        set_mode(6, 7, 9, 12, 3, 8, 9, 11, 0, 0, 0, 0);
        measure_frame(1, 1, flen, nde, nhs, nvs, fde, sidx, sline, srb);
        chk("R10 frame length unchanged", flen, 160);
        chk("R10 de count unchanged", nde, 32);
        stop_count(m);
        enable = 1'b1;
        wait_vblank(ok);
        chk("R10 new mode frame_count", int'(frame_count), 0);
        measure_frame(1, 1, flen, nde, nhs, nvs, fde, sidx, sline, srb);
        chk("R10 new mode after restart", flen, 132);

        // R9 re-enable cancels the stop
        enable = 1'b0;
        repeat (10) @(negedge clk);
        enable = 1'b1;
        m = 0;
        while (!vblank && m < 2000) begin
            if (disable_done) m = 5000;
            @(negedge clk);
            m++;
        end
        chk("R9 cancelled stop keeps running", int'(active), 1);
        chk("R9 cancelled stop no done", (m < 2000) ? 1 : 0, 1);
        stop_count(m);

        // R7 fill colour
        set_mode(8, 10, 12, 16, 4, 6, 7, 10, 0, 0, 0, 0);
        enable = 1'b1;
        wait_vblank(ok);
        chk("R7 border fill valid", int'(fill_valid), 1);
        chk("R7 border fill value", int'(fill_data), 0);
        while (!de) @(negedge clk);
        chk("R7 active no fill", int'(fill_valid), 0);
        underflow = 1'b1;
        #1;
        chk("R7 underflow fill valid", int'(fill_valid), 1);
        chk("R7 underflow fill value", int'(fill_data), 255);
        @(negedge clk);
        while (de) @(negedge clk);
        chk("R7 border during underflow value", int'(fill_data), 0);
        underflow = 1'b0;
        stop_count(m);
        chk("R9 final stop", int'(disable_done), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule